// File: doc/BRIEF.md
# Hot-Plug Slot Event Notifier

This block records insertion and removal events for up to 32 expansion slots and reports them to system software. Two 32-bit status words hold the outcome: one marks the slot that most recently gained a device, the other marks the slot that most recently lost one. Each event wipes both words before it records its own bit. As a result, software only ever sees the latest event. The words can also be read and overwritten through a small word-addressed register port.

Every event raises a one-cycle set strobe toward general-purpose event status bit 1, which is stored outside the block. When that event's enable bit (an input) is high, the block also emits a one-cycle system control interrupt pulse. A write to the eject word asks for a slot to be released. The block picks the lowest set bit of the written value and drives a one-cycle, one-hot eject pulse for that slot.

Top module: `hp_slot_notify`

## Requirements
- R1: After a synchronous reset both status words read zero, and `gpe1_set`, `sci_pulse` and `eject_pulse` are low.
- R2: The insertion word is at byte offset 0x0 and the removal word at 0x4. Both can be written and read as full 32-bit values, and a write takes effect in the cycle after the write. Reads at any offset other than 0x0 and 0x4 return zero. Writes at any offset other than 0x0, 0x4 and 0x8 change nothing.
- R3: An insertion event in slot N sets the insertion word to exactly bit N and clears the removal word. The result is readable in the cycle after the event is sampled.
- R4: A removal event in slot N sets the removal word to exactly bit N and clears the insertion word, with the same one-cycle latency as R3.
- R5: Every handled event drives `gpe1_set` high for exactly one cycle, in the cycle after the event is handled.
- R6: `sci_pulse` goes high together with `gpe1_set` only if `gpe1_enable` was high in the cycle the event was handled. Otherwise it stays low.
- R7: A write of a nonzero value V at byte offset 0x8 drives `eject_pulse` high in the next cycle for one cycle only. The pulse has exactly one bit set, at the position of the least significant 1 in V.
- R8: A write of zero at offset 0x8 produces no eject pulse.
- R9: A read at offset 0x8 returns zero.
- R10: When an insertion and a removal are presented in the same cycle, the insertion is handled in that cycle and the removal in the following cycle. The event source must present no new event in that following cycle.
- R11: When an event and a register write to either status word fall in the same cycle, the event's result is what remains in both words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| add_valid | input | 1 | Insertion event this cycle |
| add_slot | input | 5 | Slot of the insertion |
| rem_valid | input | 1 | Removal event this cycle |
| rem_slot | input | 5 | Slot of the removal |
| gpe1_enable | input | 1 | Enable bit 1 of the general-purpose event block |
| gpe1_set | output | 1 | One-cycle strobe that sets event status bit 1 |
| sci_pulse | output | 1 | One-cycle interrupt pulse |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational from offset) |
| eject_pulse | output | 32 | One-hot, one-cycle eject request per slot |

## Verification
Read data is combinational from the offset, so it reflects the words as they stand after the most recent clock edge. The status words, `gpe1_set`, `sci_pulse` and `eject_pulse` all change one edge after their event or write is sampled. In the deferred case of R10, the removal's results appear one edge later still. The reference model advances on the same rising edge that the design registers on, using inputs that were driven on the preceding falling edge. Every output is compared on the next falling edge, which is the first instant where both the design and the model have settled.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int HP_SLOTS  = 32;
    localparam int HP_SLOT_W = $clog2(HP_SLOTS);
    localparam int HP_DATA_W = 32;
    localparam int HP_ADDR_W = 4;

    localparam logic [HP_ADDR_W-1:0] OFF_UP    = 4'h0;
    localparam logic [HP_ADDR_W-1:0] OFF_DOWN  = 4'h4;
    localparam logic [HP_ADDR_W-1:0] OFF_EJECT = 4'h8;

    typedef logic [HP_SLOT_W-1:0] slot_t;
    typedef logic [HP_SLOTS-1:0]  slot_map_t;

    typedef struct packed {
        logic  valid;
        logic  is_add;
        slot_t slot;
    } hp_event_t;

    typedef struct packed {
        logic wr_up;
        logic wr_down;
        logic wr_eject;
    } csr_wr_t;

    function automatic slot_map_t slot_bit(input slot_t s);
        slot_map_t m;
        m = '0;
        m[s] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/hp_event_arb.sv
module hp_event_arb
    import hp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      add_valid,
    input  slot_t     add_slot,
    input  logic      rem_valid,
    input  slot_t     rem_slot,
    output hp_event_t ev
);

    logic  defer_q;
    slot_t defer_slot_q;

    always_comb begin
        ev = '0;
        if (defer_q) begin
            ev.valid  = 1'b1;
            ev.is_add = 1'b0;
            ev.slot   = defer_slot_q;
        end else if (add_valid) begin
            ev.valid  = 1'b1;
            ev.is_add = 1'b1;
            ev.slot   = add_slot;
        end else if (rem_valid) begin
            ev.valid  = 1'b1;
            ev.is_add = 1'b0;
            ev.slot   = rem_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            defer_q      <= 1'b0;
            defer_slot_q <= '0;
        end else if (defer_q) begin
            defer_q <= 1'b0;
        end else if (add_valid && rem_valid) begin
            defer_q      <= 1'b1;
            defer_slot_q <= rem_slot;
        end
    end

    // R10: a simultaneous pair yields the removal in the following cycle
    a_r10_deferred_removal: assert property (@(posedge clk) disable iff (rst)
        (add_valid && rem_valid && !defer_q) |=>
            (ev.valid && !ev.is_add && ev.slot == $past(rem_slot)));

endmodule

// File: rtl/hp_slot_bitmaps.sv
module hp_slot_bitmaps
    import hp_pkg::*;
#(
    parameter int DATA_W = HP_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  hp_event_t         ev,
    input  csr_wr_t           wr,
    input  logic [DATA_W-1:0] wdata,
    output slot_map_t         up_map,
    output slot_map_t         down_map
);

    slot_map_t up_q, down_q;
    slot_map_t ev_mask;

    assign ev_mask = slot_bit(ev.slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q   <= '0;
            down_q <= '0;
        end else if (ev.valid) begin
            up_q   <= ev.is_add ? ev_mask : '0;
            down_q <= ev.is_add ? '0 : ev_mask;
        end else begin
            if (wr.wr_up)   up_q   <= wdata[HP_SLOTS-1:0];
            if (wr.wr_down) down_q <= wdata[HP_SLOTS-1:0];
        end
    end

    assign up_map   = up_q;
    assign down_map = down_q;

    // R3 / R4: after any event exactly one bit is left across both words
    a_r3_single_bit: assert property (@(posedge clk) disable iff (rst)
        ev.valid |=> ($countones(up_q | down_q) == 1));

    // R11: an insertion overrides a concurrent write to the insertion word
    a_r11_event_wins: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && ev.is_add) |=> up_q[$past(ev.slot)]);

endmodule

// File: rtl/hp_eject_dec.sv
module hp_eject_dec
    import hp_pkg::*;
#(
    parameter int DATA_W = HP_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_eject,
    input  logic [DATA_W-1:0] wdata,
    output slot_map_t         eject
);

    logic [HP_SLOTS:0] below;
    slot_map_t         first_hit;
    slot_map_t         eject_q;

    assign below[0] = 1'b0;

    generate
        for (genvar i = 0; i < HP_SLOTS; i++) begin : g_chain
            assign first_hit[i] = wdata[i] & ~below[i];
            assign below[i+1]   = below[i] | wdata[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) eject_q <= '0;
        else     eject_q <= wr_eject ? first_hit : '0;
    end

    assign eject = eject_q;

    // R7: never more than one slot ejected at a time
    a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eject_q));

    // R8: a pulse only follows an eject write carrying a nonzero value
    a_r8_needs_nonzero: assert property (@(posedge clk) disable iff (rst)
        (eject_q != '0) |-> $past(wr_eject && (wdata[HP_SLOTS-1:0] != '0)));

endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
    import hp_pkg::*;
#(
    parameter int DATA_W = HP_DATA_W,
    parameter int ADDR_W = HP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_valid,
    input  logic [4:0]        add_slot,
    input  logic              rem_valid,
    input  logic [4:0]        rem_slot,
    input  logic              gpe1_enable,
    output logic              gpe1_set,
    output logic              sci_pulse,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic [31:0]       eject_pulse
);

    hp_event_t ev;
    csr_wr_t   wr;
    slot_map_t up_map, down_map;
    logic      gpe_q, sci_q;

    assign wr.wr_up    = csr_we && (csr_addr == OFF_UP);
    assign wr.wr_down  = csr_we && (csr_addr == OFF_DOWN);
    assign wr.wr_eject = csr_we && (csr_addr == OFF_EJECT);

    hp_event_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .add_valid (add_valid),
        .add_slot  (add_slot),
        .rem_valid (rem_valid),
        .rem_slot  (rem_slot),
        .ev        (ev)
    );

    hp_slot_bitmaps #(.DATA_W(DATA_W)) u_maps (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .wr       (wr),
        .wdata    (csr_wdata),
        .up_map   (up_map),
        .down_map (down_map)
    );

    hp_eject_dec #(.DATA_W(DATA_W)) u_eject (
        .clk      (clk),
        .rst      (rst),
        .wr_eject (wr.wr_eject),
        .wdata    (csr_wdata),
        .eject    (eject_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gpe_q <= 1'b0;
            sci_q <= 1'b0;
        end else begin
            gpe_q <= ev.valid;
            sci_q <= ev.valid && gpe1_enable;
        end
    end

    assign gpe1_set  = gpe_q;
    assign sci_pulse = sci_q;

    always_comb begin
        csr_rdata = '0;
        unique case (csr_addr)
            OFF_UP:   csr_rdata[HP_SLOTS-1:0] = up_map;
            OFF_DOWN: csr_rdata[HP_SLOTS-1:0] = down_map;
            default:  csr_rdata = '0;
        endcase
    end

    // R6: the interrupt never fires without the status-set strobe
    a_r6_sci_with_set: assert property (@(posedge clk) disable iff (rst)
        sci_pulse |-> gpe1_set);

    // R6: a disabled event gives no interrupt
    a_r6_gate_low: assert property (@(posedge clk) disable iff (rst)
        !$past(gpe1_enable) |-> !sci_pulse);

endmodule

// File: tb/tb_hp_slot_notify.sv
module tb_hp_slot_notify;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        add_valid = 1'b0, rem_valid = 1'b0;
    logic [4:0]  add_slot = '0, rem_slot = '0;
    logic        gpe1_enable = 1'b0;
    logic        gpe1_set, sci_pulse;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] eject_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;   // 50 MHz

    hp_slot_notify dut (
        .clk(clk), .rst(rst),
        .add_valid(add_valid), .add_slot(add_slot),
        .rem_valid(rem_valid), .rem_slot(rem_slot),
        .gpe1_enable(gpe1_enable), .gpe1_set(gpe1_set), .sci_pulse(sci_pulse),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .eject_pulse(eject_pulse)
    );

    // behavioural reference model
    logic [31:0] m_up = '0, m_down = '0, m_eject = '0;
    bit          m_gpe = 0, m_sci = 0;
    bit          m_hold = 0;
    int          m_hold_slot = 0;

    always @(posedge clk) begin
        bit served, kind_add;
        int slot;
        served = 0; kind_add = 0; slot = 0;
        if (rst) begin
            m_up = '0; m_down = '0; m_eject = '0;
            m_gpe = 0; m_sci = 0; m_hold = 0;
        end else begin
            if (m_hold) begin
                served = 1; kind_add = 0; slot = m_hold_slot; m_hold = 0;
            end else if (add_valid) begin
                served = 1; kind_add = 1; slot = add_slot;
                if (rem_valid) begin m_hold = 1; m_hold_slot = rem_slot; end
            end else if (rem_valid) begin
                served = 1; kind_add = 0; slot = rem_slot;
            end
            if (csr_we && csr_addr == 4'h0) m_up   = csr_wdata;
            if (csr_we && csr_addr == 4'h4) m_down = csr_wdata;
            if (served) begin
                m_up = '0; m_down = '0;
                if (kind_add) m_up[slot] = 1'b1;
                else          m_down[slot] = 1'b1;
            end
            m_gpe = served;
            m_sci = served && gpe1_enable;
            m_eject = '0;
            if (csr_we && csr_addr == 4'h8) begin
                for (int i = 31; i >= 0; i--)
                    if (csr_wdata[i]) m_eject = 32'h1 << i;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // every-cycle comparison on the falling edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        string       rd_req;
        if (!rst) begin
            case (csr_addr)
                4'h0:    begin exp_rd = m_up;   rd_req = "R3"; end
                4'h4:    begin exp_rd = m_down; rd_req = "R4"; end
                4'h8:    begin exp_rd = '0;     rd_req = "R9"; end
                default: begin exp_rd = '0;     rd_req = "R2"; end
            endcase
            check(rd_req, "rdata", csr_rdata, exp_rd);
            check("R5", "gpe1_set", {31'b0, gpe1_set}, {31'b0, m_gpe});
            check("R6", "sci_pulse", {31'b0, sci_pulse}, {31'b0, m_sci});
            check("R7", "eject_pulse", eject_pulse, m_eject);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            n_fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ev_add(input int s, input bit en);
        add_valid = 1; add_slot = 5'(s); gpe1_enable = en;
        @(negedge clk);
        add_valid = 0; gpe1_enable = 0;
    endtask

    task automatic ev_rem(input int s, input bit en);
        rem_valid = 1; rem_slot = 5'(s); gpe1_enable = en;
        @(negedge clk);
        rem_valid = 0; gpe1_enable = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        csr_we = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 0;
    endtask

    initial begin
        idle(3);
        rst = 0;
        // R1: reset state seen through both words and all strobes
        csr_addr = 4'h0; #1;
        check("R1", "up after reset", csr_rdata, 32'h0);
        csr_addr = 4'h4; #1;
        check("R1", "down after reset", csr_rdata, 32'h0);
        check("R1", "strobes after reset", {eject_pulse[29:0], gpe1_set, sci_pulse}, 32'h0);
        idle(1);

        // R2: direct writes and readback, stray offset ignored
        wr(4'h0, 32'hDEAD_BEEF); csr_addr = 4'h0; idle(1);
        wr(4'h4, 32'h1234_5678); csr_addr = 4'h4; idle(1);
        wr(4'hC, 32'hFFFF_FFFF); csr_addr = 4'h0; idle(1);
        csr_addr = 4'h4; idle(1);
        csr_addr = 4'hC; idle(1);

        // R3: insertions at edge slots, with and without the enable (R6)
        csr_addr = 4'h0;
        ev_add(0, 1); idle(1);
        ev_add(31, 0); idle(1);
        ev_add(5, 1);
        csr_addr = 4'h4; idle(1);

        // R4: removal clears the insertion word
        ev_rem(7, 1); idle(1);
        csr_addr = 4'h0; idle(1);
        ev_rem(31, 0); idle(1);

        // R10: simultaneous pair, insertion then removal
        csr_addr = 4'h0;
        add_valid = 1; add_slot = 5'd3; rem_valid = 1; rem_slot = 5'd9; gpe1_enable = 1;
        @(negedge clk);
        add_valid = 0; rem_valid = 0;
        check("R10", "up after pair, first cycle", csr_rdata, 32'h8);
        @(negedge clk);
        gpe1_enable = 0;
        check("R10", "up after pair, second cycle", csr_rdata, 32'h0);
        csr_addr = 4'h4; #1;
        check("R10", "down after pair", csr_rdata, 32'h200);
        idle(1);

        // R11: event beats a concurrent write
        csr_we = 1; csr_addr = 4'h0; csr_wdata = 32'hFFFF_0000;
        add_valid = 1; add_slot = 5'd12;
        @(negedge clk);
        csr_we = 0; add_valid = 0;
        check("R11", "up after write+event", csr_rdata, 32'h1000);
        idle(1);

        // R7, R8, R9: eject decode
        csr_addr = 4'h8;
        wr(4'h8, 32'h0000_0001); idle(1);
        wr(4'h8, 32'h8000_0000); idle(1);
        wr(4'h8, 32'h0000_00F0);
        check("R7", "eject lowest of F0", eject_pulse, 32'h10);
        idle(1);
        wr(4'h8, 32'hFFFF_FFFF); idle(1);
        wr(4'h8, 32'h0000_0000);
        check("R8", "eject of zero", eject_pulse, 32'h0);
        csr_addr = 4'h8; #1;
        check("R9", "eject read", csr_rdata, 32'h0);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule